// File: doc/BRIEF.md
# Single-Channel One-Shot DMA Engine

This block is a single-channel DMA engine that works in one-shot mode. Software programs a source pointer, a destination pointer, a transfer count and a control word through a small register port. Each accepted request then moves one unit of data across a simple synchronous memory bus. The unit is a byte or a 16-bit word. The move is always one read cycle from the source address followed by one write cycle to the destination address. Between moves, the bus is left idle so that the processor can use it.

The request comes from one of two places. A software request bit can raise it, or a single hardware request input can raise it; a control bit picks which one is live. The engine keeps a down counter and a working pointer, which is the copy of whichever address advances. On the first move after the engine is enabled, both are loaded from their programmed registers. Completion is flagged on counter underflow, not when the counter reaches zero, so a programmed count of N gives N+1 moves. On the final move, the engine clears its own enable and raises a sticky interrupt flag.

Top module: `oneshot_dma`

## Requirements
- R1: After reset, the enable, request and interrupt bits read 0, `irq` is low, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: With the software trigger selected (control bit 3 = 1), writing 1 to control bit 1 sets the request bit. With the hardware trigger selected (bit 3 = 0), writing 1 to bit 1 leaves the request bit unchanged. In that setting, a high `hw_req` sampled at a clock edge sets the request bit.
- R3: While the enable bit (control bit 0) is 0, a set request bit stays set and the bus stays idle. Once enable is set, the held request starts a move.
- R4: An accepted request drives `mem_rd` for exactly one cycle, in the cycle after acceptance, at the source address. The next cycle is idle. Then `mem_wr` is driven for exactly one cycle at the destination address, carrying the data read. The two strobes are never high together, and at least one idle cycle follows every write.
- R5: The request bit clears when the engine accepts the request. Writing 0 to control bit 1 also clears it.
- R6: On the first move after enable goes from 0 to 1 by a control write, the transfer counter (register 5) loads from the reload register (register 3). The working pointer (register 4) loads from the register of the advancing pointer. That is the destination register in mode 1 and the source register otherwise.
- R7: Every completed move decrements the counter by one. In modes 0 and 1 it also advances the working pointer by 1 for byte units (control bit 6 = 0) or by 2 for 16-bit units (bit 6 = 1).
- R8: Control bits 5:4 select the address mode. In mode 0 the source advances and the destination is fixed. In mode 1 the source is fixed and the destination advances. In modes 2 and 3 both addresses are fixed at their programmed values.
- R9: A reload value of N yields N+1 moves. On the move that finds the counter at 0, the counter becomes all ones, enable clears to 0 and the interrupt bit (control bit 2) sets, all at the same edge.
- R10: The interrupt bit and `irq` stay set until software writes 0 to control bit 2; writing 1 there has no effect. Re-enabling the engine rearms it, so that the next move reloads per R6.
- R11: For byte units, `mem_wdata` carries the low byte of the read data with the upper byte zero, and `mem_wide` is low. For 16-bit units, all 16 bits pass through and `mem_wide` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 source, 2 destination, 3 reload, 4 working pointer (read), 5 counter (read) |
| reg_wdata | input | AW (20) | Register write data |
| reg_rdata | output | AW (20) | Read data of the selected register |
| hw_req | input | 1 | Hardware transfer request |
| mem_addr | output | AW (20) | Bus address |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` the following cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wide | output | 1 | High for 16-bit units |
| mem_wdata | output | DW (16) | Write data |
| mem_rdata | input | DW (16) | Read data |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench aims at the underflow boundary. It programs reload values of 0, 1 and 2 and counts the moves. An engine that stopped on reaching zero would come up one move short and would leave the counter at 0 instead of all ones. Separate scenarios check for leaks in the request path. A software request written while the hardware trigger is selected, or a request cleared before enable, would produce a spurious move. A request held across a disabled period that is then lost would produce no move at all. The bench also checks the per-mode addresses and the 2-byte stride for 16-bit units. A design that advanced the wrong pointer, or stepped by 1 for words, would put reads and writes at the wrong addresses. Finally, the bench re-enables with a new reload value, to catch a design that fails to reload the counter on rearm.

// File: rtl/oneshot_dma.sv
module oneshot_dma #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          hw_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_wide,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  localparam int HB = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_LAT, S_WR} state_t;
  state_t state;

  logic          en_q, req_q, irq_q, sw_q, wide_q, first_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] src_q, dst_q, wp_q;
  logic [CW-1:0] reload_q, cnt_q;
  logic [DW-1:0] data_q;

  wire inc_src = (mode_q == 2'd0);
  wire inc_dst = (mode_q == 2'd1);
  wire accept  = (state == S_IDLE) && en_q && req_q;
  wire [AW-1:0] step     = wide_q ? AW'(2) : AW'(1);
  wire [AW-1:0] src_addr = inc_src ? wp_q : src_q;
  wire [AW-1:0] dst_addr = inc_dst ? wp_q : dst_q;
  wire ctrl_wr = reg_wr && (reg_sel == 3'd0);

  assign mem_rd    = (state == S_RD);
  assign mem_wr    = (state == S_WR);
  assign mem_addr  = mem_wr ? dst_addr : src_addr;
  assign mem_wide  = wide_q;
  assign mem_wdata = wide_q ? data_q : {{(DW-HB){1'b0}}, data_q[HB-1:0]};
  assign irq       = irq_q;

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = {{(AW-7){1'b0}}, wide_q, mode_q, sw_q, irq_q, req_q, en_q};
      3'd1:    reg_rdata = src_q;
      3'd2:    reg_rdata = dst_q;
      3'd3:    reg_rdata = {{(AW-CW){1'b0}}, reload_q};
      3'd4:    reg_rdata = wp_q;
      3'd5:    reg_rdata = {{(AW-CW){1'b0}}, cnt_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      en_q     <= 1'b0;
      req_q    <= 1'b0;
      irq_q    <= 1'b0;
      sw_q     <= 1'b0;
      wide_q   <= 1'b0;
      first_q  <= 1'b0;
      mode_q   <= 2'd0;
      src_q    <= '0;
      dst_q    <= '0;
      wp_q     <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_RD;
          if (first_q) begin
            cnt_q   <= reload_q;
            wp_q    <= inc_dst ? dst_q : src_q;
            first_q <= 1'b0;
          end
        end
        S_RD:  state <= S_LAT;
        S_LAT: begin
          data_q <= mem_rdata;
          state  <= S_WR;
        end
        S_WR: begin
          state <= S_IDLE;
          if (inc_src || inc_dst) wp_q <= wp_q + step;
          if (cnt_q == '0) begin
            cnt_q <= '1;
            en_q  <= 1'b0;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (accept) req_q <= 1'b0;
      if (!sw_q && hw_req) req_q <= 1'b1;

      if (ctrl_wr) begin
        en_q   <= reg_wdata[0];
        sw_q   <= reg_wdata[3];
        mode_q <= reg_wdata[5:4];
        wide_q <= reg_wdata[6];
        if (reg_wdata[0] && !en_q) first_q <= 1'b1;
        if (!reg_wdata[1]) req_q <= 1'b0;
        else if (reg_wdata[3]) req_q <= 1'b1;
        if (!reg_wdata[2]) irq_q <= 1'b0;
      end
      if (reg_wr && reg_sel == 3'd1) src_q    <= reg_wdata;
      if (reg_wr && reg_sel == 3'd2) dst_q    <= reg_wdata;
      if (reg_wr && reg_sel == 3'd3) reload_q <= reg_wdata[CW-1:0];
    end
  end
endmodule

// File: rtl/oneshot_dma_chk.sv
module oneshot_dma_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          irq,
  input logic          en,
  input logic [CW-1:0] cnt
);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!mem_rd && !mem_wr) ##1 mem_wr);

  assert_gap_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (!mem_rd && !mem_wr));

  assert_no_bus_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(en));

  assert_underflow_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!en && cnt == '1));
endmodule

bind oneshot_dma oneshot_dma_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .irq(irq), .en(en_q), .cnt(cnt_q)
);

// File: tb/oneshot_dma_test.sv
module oneshot_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic        hw_req = 1'b0;
  logic [19:0] mem_addr;
  logic        mem_rd, mem_wr, mem_wide;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  logic [19:0] rd_log [0:63];
  logic [19:0] wa_log [0:63];
  logic [15:0] wd_log [0:63];
  int nrd = 0;
  int nwr = 0;

  always #4 clk = ~clk;

  oneshot_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wide(mem_wide),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  function automatic logic [15:0] mv(logic [7:0] a);
    return 16'h5A00 ^ (16'(a) * 16'h0103);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mv(mem_addr[7:0]);
      if (nrd < 64) rd_log[nrd] <= mem_addr;
      nrd <= nrd + 1;
    end
    if (mem_wr) begin
      if (nwr < 64) begin
        wa_log[nwr] <= mem_addr;
        wd_log[nwr] <= mem_wdata;
      end
      nwr <= nwr + 1;
    end
  end

  function automatic logic [19:0] ctrl(bit en, bit req, bit irqb, bit sw, logic [1:0] mode, bit wide);
    return {13'd0, wide, mode, sw, irqb, req, en};
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regwr(logic [2:0] sel, logic [19:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic regrd(logic [2:0] sel, output logic [19:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic xfer_check(string tag, int k, logic [19:0] ra, logic [19:0] wa, logic [15:0] wd);
    chk({tag, " read address"}, 32'(rd_log[k]), 32'(ra));
    chk({tag, " write address"}, 32'(wa_log[k]), 32'(wa));
    chk({tag, " write data"}, 32'(wd_log[k]), 32'(wd));
  endtask

  task automatic t_reset;
    logic [19:0] v;
    regrd(3'd0, v);
    chk("R1 control bits after reset", 32'(v[2:0]), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 strobes after reset", 32'({mem_rd, mem_wr}), 0);
  endtask

  task automatic t_mode0_byte;
    logic [19:0] v;
    regwr(3'd1, 20'h00010);
    regwr(3'd2, 20'h00080);
    regwr(3'd3, 20'd2);
    regwr(3'd0, ctrl(1, 0, 0, 1, 2'd0, 0));
    regwr(3'd0, ctrl(1, 1, 1, 1, 2'd0, 0));
    tick();
    chk("R4 read strobe one cycle after accept", 32'({mem_rd, mem_wr}), 32'b10);
    chk("R4 R8 read at source", 32'(mem_addr), 32'h10);
    tick();
    chk("R4 idle cycle between read and write", 32'({mem_rd, mem_wr}), 0);
    tick();
    chk("R4 write strobe", 32'({mem_rd, mem_wr}), 32'b01);
    chk("R8 write at fixed destination", 32'(mem_addr), 32'h80);
    chk("R11 byte data low byte only", 32'(mem_wdata), 32'({8'h00, mv(8'h10)[7:0]}));
    chk("R11 byte width flag", 32'(mem_wide), 0);
    tick();
    chk("R4 idle after write", 32'({mem_rd, mem_wr}), 0);
    regrd(3'd5, v);
    chk("R6 R7 counter after first move", 32'(v), 1);
    regrd(3'd4, v);
    chk("R7 pointer step 1 for bytes", 32'(v), 32'h11);
    regrd(3'd0, v);
    chk("R5 request cleared on accept", 32'(v[1]), 0);
    for (int k = 1; k < 3; k++) begin
      regwr(3'd0, ctrl(1, 1, 1, 1, 2'd0, 0));
      tick(6);
    end
    chk("R9 reload 2 gives 3 moves", 32'(nwr), 3);
    xfer_check("R8 mode0 move 2", 1, 20'h11, 20'h80, {8'h00, mv(8'h11)[7:0]});
    xfer_check("R8 mode0 move 3", 2, 20'h12, 20'h80, {8'h00, mv(8'h12)[7:0]});
    regrd(3'd0, v);
    chk("R9 enable cleared and irq bit set", 32'(v[2:0]), 32'b100);
    chk("R9 irq output", 32'(irq), 1);
    regrd(3'd5, v);
    chk("R9 counter underflows to all ones", 32'(v), 32'hFF);
    regwr(3'd0, ctrl(0, 1, 1, 1, 2'd0, 0));
    tick(6);
    chk("R3 no move after completion while disabled", 32'(nrd), 3);
    chk("R10 irq held", 32'(irq), 1);
  endtask

  task automatic t_mode1_wide;
    logic [19:0] v;
    regwr(3'd1, 20'h00020);
    regwr(3'd2, 20'h00040);
    regwr(3'd3, 20'd1);
    regwr(3'd0, ctrl(1, 0, 0, 1, 2'd1, 1));
    chk("R10 irq cleared by writing 0", 32'(irq), 0);
    regwr(3'd0, ctrl(1, 1, 1, 1, 2'd1, 1));
    tick(6);
    regrd(3'd5, v);
    chk("R6 R10 counter reloaded after rearm", 32'(v), 0);
    regrd(3'd4, v);
    chk("R6 R7 pointer from destination, step 2", 32'(v), 32'h42);
    regwr(3'd0, ctrl(1, 1, 1, 1, 2'd1, 1));
    tick(6);
    chk("R9 reload 1 gives 2 moves", 32'(nwr), 5);
    xfer_check("R8 R11 mode1 move 1", 3, 20'h20, 20'h40, mv(8'h20));
    xfer_check("R8 R11 mode1 move 2", 4, 20'h20, 20'h42, mv(8'h20));
    chk("R9 irq after mode1", 32'(irq), 1);
  endtask

  task automatic t_mode2_fixed;
    logic [19:0] v;
    regwr(3'd1, 20'h00033);
    regwr(3'd2, 20'h00077);
    regwr(3'd3, 20'd0);
    regwr(3'd0, ctrl(1, 0, 0, 1, 2'd2, 0));
    regwr(3'd0, ctrl(1, 1, 1, 1, 2'd2, 0));
    tick(6);
    chk("R9 reload 0 gives 1 move", 32'(nwr), 6);
    xfer_check("R8 mode2 both fixed", 5, 20'h33, 20'h77, {8'h00, mv(8'h33)[7:0]});
    regrd(3'd4, v);
    chk("R7 R8 no pointer advance in mode2", 32'(v), 32'h33);
    regrd(3'd0, v);
    chk("R9 done after single move", 32'(v[2:0]), 32'b100);
  endtask

  task automatic t_hw_trigger;
    logic [19:0] v;
    regwr(3'd1, 20'h00050);
    regwr(3'd2, 20'h00090);
    regwr(3'd3, 20'd3);
    regwr(3'd0, ctrl(1, 1, 0, 0, 2'd0, 0));
    tick(6);
    regrd(3'd0, v);
    chk("R2 software request ignored under hardware trigger", 32'(v[1]), 0);
    chk("R2 no move from ignored request", 32'(nwr), 6);
    hw_req = 1'b1;
    tick();
    hw_req = 1'b0;
    tick(6);
    chk("R2 hardware request moves one unit", 32'(nwr), 7);
    xfer_check("R2 hardware move", 6, 20'h50, 20'h90, {8'h00, mv(8'h50)[7:0]});
    regrd(3'd5, v);
    chk("R7 counter after hardware move", 32'(v), 2);
  endtask

  task automatic t_disabled_hold;
    logic [19:0] v;
    regwr(3'd1, 20'h00060);
    regwr(3'd2, 20'h000A0);
    regwr(3'd3, 20'd5);
    regwr(3'd0, ctrl(0, 1, 0, 1, 2'd0, 0));
    tick(6);
    regrd(3'd0, v);
    chk("R3 request held while disabled", 32'(v[1]), 1);
    chk("R3 bus idle while disabled", 32'(nrd), 7);
    regwr(3'd0, ctrl(1, 1, 0, 1, 2'd0, 0));
    tick(6);
    chk("R3 held request runs on enable", 32'(nwr), 8);
    xfer_check("R3 R6 move after enable", 7, 20'h60, 20'hA0, {8'h00, mv(8'h60)[7:0]});
    regrd(3'd5, v);
    chk("R6 counter loaded on first move", 32'(v), 4);
    regwr(3'd0, ctrl(0, 1, 0, 1, 2'd0, 0));
    regwr(3'd0, ctrl(0, 0, 0, 1, 2'd0, 0));
    regrd(3'd0, v);
    chk("R5 request cleared by software", 32'(v[1]), 0);
    regwr(3'd0, ctrl(1, 0, 0, 1, 2'd0, 0));
    tick(6);
    chk("R5 cleared request starts nothing", 32'(nwr), 8);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_mode0_byte();
    t_mode1_wide();
    t_mode2_fixed();
    t_hw_trigger();
    t_disabled_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule